// File: doc/BRIEF.md
# Branch Confidence Estimator

This block assigns a confidence bit to each predicted conditional branch so that a front end can throttle fetch behind branches that are likely to be wrong. It offers three rules, selected by a mode input. The streak rule keeps a small table of per-branch counters of consecutive correct predictions. The bias rule looks at how strongly the predictor's own 2-bit counter leans. The distance rule distrusts the few branches fetched right after a mispredict.

A lookup presents a PC and the predictor's counter value, and the confidence bit comes back in the same cycle. An update presents the PC of a resolved branch, whether it was mispredicted, and the confidence class that branch was given at lookup. Four saturating event counters accumulate the numbers needed for coverage (mispredicts caught as low-confidence) and accuracy (low-confidence branches that really were wrong). The mode and the streak threshold are configuration inputs. They are taken in only during a cycle with no lookup and no update, so a rule cannot change between a lookup and its update.

Top module: `branch_conf_est`

## Requirements
- R1: Streak mode (mode 0, and also mode 3): `lk_high` is 1 when the table entry for `lk_pc` is greater than or equal to the active threshold. Each correct update adds one to the entry, and the entry saturates at 15.
- R2: A mispredicted update clears the streak entry of its PC to zero.
- R3: The streak table is direct-mapped with 64 entries indexed by PC bits [7:2]. PCs that differ only in bits at or above bit 8 share an entry, and PCs that differ in bits [7:2] do not.
- R4: Bias mode (mode 1): `lk_high` is 0 when `lk_ctr` is 2'b01 or 2'b10, and 1 when it is 2'b00 or 2'b11.
- R5: Distance mode (mode 2): after a mispredicted update, the next 4 lookups return `lk_high`=0 and the fifth returns 1. The window counts lookups in every mode.
- R6: A mispredicted update while a distance window is still open restarts the window at 4 lookups.
- R7: `cfg_mode` and `cfg_thresh` are loaded only at a clock edge where both `lk_valid` and `up_valid` are 0. A change presented during a busy cycle has no effect on that cycle's lookup.
- R8: A lookup is combinational. An update changes state only from the following clock edge, so a lookup in the same cycle as an update to its entry sees the old value.
- R9: Coverage counters: `st_misp` counts mispredicted updates, and `st_misp_low` counts those marked low-confidence (`up_low`=1).
- R10: Accuracy counters: `st_low` counts updates marked low-confidence, and `st_low_misp` counts those that were mispredicted.
- R11: Reset clears all table entries, closes the distance window, zeroes the counters and loads the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Rule select: 0 streak, 1 bias, 2 distance, 3 streak |
| cfg_thresh | input | 4 | Streak threshold N |
| lk_valid | input | 1 | Lookup present |
| lk_pc | input | 32 | Lookup branch PC |
| lk_ctr | input | 2 | Predictor 2-bit counter for the looked-up branch |
| lk_high | output | 1 | 1 = high confidence |
| up_valid | input | 1 | Resolved-branch update present |
| up_pc | input | 32 | Update branch PC |
| up_mispred | input | 1 | 1 = branch was mispredicted |
| up_low | input | 1 | Class given at lookup, 1 = low confidence |
| st_misp | output | 16 | Mispredicted updates |
| st_misp_low | output | 16 | Mispredicted updates that were low-confidence |
| st_low | output | 16 | Low-confidence updates |
| st_low_misp | output | 16 | Low-confidence updates that were mispredicted |

## Verification
The bench checks the threshold edge: an entry exactly at N must read high and one below N must read low, so an off-by-one comparison flips a result. Aliasing PCs must share an entry and neighbouring PCs must not, which catches a wrong choice of index bits. A second mispredict inside an open distance window must restart the count, so a design that ignores it returns high too early. A threshold at 15 after a long run of correct updates catches a counter that wraps instead of saturating. Other checks cover a configuration change made in a busy cycle, a lookup in the same cycle as an update to its own entry, and all four predictor counter values in bias mode.

// File: rtl/conf_pkg.sv
package conf_pkg;
    localparam int PC_W      = 32;
    localparam int ENTRIES   = 64;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int STREAK_W  = 4;
    localparam int WINDOW    = 4;
    localparam int WIN_W     = $clog2(WINDOW + 1);
    localparam int STAT_W    = 16;

    typedef enum logic [1:0] {
        RULE_STREAK = 2'd0,
        RULE_BIAS   = 2'd1,
        RULE_DIST   = 2'd2,
        RULE_ALT    = 2'd3
    } rule_e;

    typedef struct packed {
        rule_e               rule;
        logic [STREAK_W-1:0] thresh;
    } cfg_t;

    function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic logic ctr_biased(input logic [1:0] ctr);
        return (ctr == 2'b00) || (ctr == 2'b11);
    endfunction
endpackage

// File: rtl/conf_streak_table.sv
module conf_streak_table
    import conf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PC_W-1:0]     rd_pc,
    output logic [STREAK_W-1:0] rd_cnt,
    input  logic                wr_en,
    input  logic [PC_W-1:0]     wr_pc,
    input  logic                wr_mis
);
    localparam logic [STREAK_W-1:0] CNT_MAX = {STREAK_W{1'b1}};

    logic [STREAK_W-1:0] tbl [ENTRIES];
    logic [IDX_W-1:0]    wr_idx;

    assign wr_idx = pc_index(wr_pc);
    assign rd_cnt = tbl[pc_index(rd_pc)];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            if (wr_mis)
                tbl[wr_idx] <= '0;
            else if (tbl[wr_idx] != CNT_MAX)
                tbl[wr_idx] <= tbl[wr_idx] + 1'b1;
        end
    end

    AST_STREAK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mis) |=> (tbl[$past(wr_idx)] == '0)); // R2

    AST_STREAK_SAT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_mis && tbl[wr_idx] == CNT_MAX) |=> (tbl[$past(wr_idx)] == CNT_MAX)); // R1
endmodule

// File: rtl/conf_dist_window.sv
module conf_dist_window
    import conf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lk_fire,
    input  logic mis_fire,
    output logic in_window
);
    localparam logic [WIN_W-1:0] RELOAD = WIN_W'(WINDOW);

    logic [WIN_W-1:0] left_q;

    assign in_window = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (mis_fire)
            left_q <= RELOAD;
        else if (lk_fire && in_window)
            left_q <= left_q - 1'b1;
    end

    AST_DIST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        mis_fire |=> (left_q == RELOAD)); // R6

    AST_DIST_BOUND: assert property (@(posedge clk) disable iff (rst)
        left_q <= RELOAD); // R5

    AST_DIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mis_fire && !lk_fire) |=> $stable(left_q)); // R5
endmodule

// File: rtl/conf_stats.sv
module conf_stats
    import conf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_mis,
    input  logic              ev_low,
    output logic [STAT_W-1:0] n_misp,
    output logic [STAT_W-1:0] n_misp_low,
    output logic [STAT_W-1:0] n_low,
    output logic [STAT_W-1:0] n_low_misp
);
    logic [3:0]             hit;
    logic [STAT_W-1:0]      cnt_q [4];

    assign hit[0] = ev_valid && ev_mis;
    assign hit[1] = ev_valid && ev_mis && ev_low;
    assign hit[2] = ev_valid && ev_low;
    assign hit[3] = ev_valid && ev_low && ev_mis;

    for (genvar g = 0; g < 4; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (hit[g] && (cnt_q[g] != {STAT_W{1'b1}}))
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    assign n_misp     = cnt_q[0];
    assign n_misp_low = cnt_q[1];
    assign n_low      = cnt_q[2];
    assign n_low_misp = cnt_q[3];

    AST_COV_ORDER: assert property (@(posedge clk) disable iff (rst)
        n_misp_low <= n_misp); // R9

    AST_ACC_ORDER: assert property (@(posedge clk) disable iff (rst)
        n_low_misp <= n_low); // R10

    AST_STAT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> ($stable(n_misp) && $stable(n_low))); // R9
endmodule

// File: rtl/branch_conf_est.sv
module branch_conf_est
    import conf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [3:0]        cfg_thresh,
    input  logic              lk_valid,
    input  logic [31:0]       lk_pc,
    input  logic [1:0]        lk_ctr,
    output logic              lk_high,
    input  logic              up_valid,
    input  logic [31:0]       up_pc,
    input  logic              up_mispred,
    input  logic              up_low,
    output logic [15:0]       st_misp,
    output logic [15:0]       st_misp_low,
    output logic [15:0]       st_low,
    output logic [15:0]       st_low_misp
);
    cfg_t                cfg_q;
    cfg_t                cfg_in;
    logic                idle;
    logic [STREAK_W-1:0] streak_cnt;
    logic                in_window;
    logic                mis_fire;

    assign cfg_in.rule   = rule_e'(cfg_mode);
    assign cfg_in.thresh = cfg_thresh;
    assign idle          = !lk_valid && !up_valid;
    assign mis_fire      = up_valid && up_mispred;

    always_ff @(posedge clk) begin
        if (rst || idle)
            cfg_q <= cfg_in;
    end

    conf_streak_table u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_pc  (lk_pc),
        .rd_cnt (streak_cnt),
        .wr_en  (up_valid),
        .wr_pc  (up_pc),
        .wr_mis (up_mispred)
    );

    conf_dist_window u_window (
        .clk       (clk),
        .rst       (rst),
        .lk_fire   (lk_valid),
        .mis_fire  (mis_fire),
        .in_window (in_window)
    );

    conf_stats u_stats (
        .clk        (clk),
        .rst        (rst),
        .ev_valid   (up_valid),
        .ev_mis     (up_mispred),
        .ev_low     (up_low),
        .n_misp     (st_misp),
        .n_misp_low (st_misp_low),
        .n_low      (st_low),
        .n_low_misp (st_low_misp)
    );

    always_comb begin
        unique case (cfg_q.rule)
            RULE_BIAS: lk_high = ctr_biased(lk_ctr);
            RULE_DIST: lk_high = !in_window;
            default:   lk_high = (streak_cnt >= cfg_q.thresh);
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lk_valid || up_valid) |=> $stable(cfg_q)); // R7

    AST_BIAS_WEAK: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rule == RULE_BIAS && (lk_ctr == 2'b01 || lk_ctr == 2'b10)) |-> !lk_high); // R4

    AST_DIST_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rule == RULE_DIST && mis_fire) |=> !lk_high); // R5
endmodule

// File: tb/branch_conf_est_bench.sv
module branch_conf_est_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_mode;
    logic [3:0]  cfg_thresh;
    logic        lk_valid;
    logic [31:0] lk_pc;
    logic [1:0]  lk_ctr;
    logic        lk_high;
    logic        up_valid;
    logic [31:0] up_pc;
    logic        up_mispred;
    logic        up_low;
    logic [15:0] st_misp, st_misp_low, st_low, st_low_misp;

    int checks = 0;
    int failures = 0;
    int e_misp = 0, e_misp_low = 0, e_low = 0, e_low_misp = 0;
    bit done = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    branch_conf_est u_branch_conf_est (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_ctr(lk_ctr), .lk_high(lk_high),
        .up_valid(up_valid), .up_pc(up_pc), .up_mispred(up_mispred), .up_low(up_low),
        .st_misp(st_misp), .st_misp_low(st_misp_low), .st_low(st_low), .st_low_misp(st_low_misp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one cycle, optional lookup (expected pushed) and optional update.
    task automatic op(input bit lv, input logic [31:0] pc, input logic [1:0] ctr, input logic exp,
                      input string tag, input bit uv, input logic [31:0] upc,
                      input bit mis, input bit low);
        @(negedge clk);
        lk_valid = lv; lk_pc = pc; lk_ctr = ctr;
        up_valid = uv; up_pc = upc; up_mispred = mis; up_low = low;
        if (lv) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        if (uv) begin
            if (mis) e_misp++;
            if (mis && low) e_misp_low++;
            if (low) e_low++;
            if (low && mis) e_low_misp++;
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [1:0] ctr, input logic exp, input string tag);
        op(1, pc, ctr, exp, tag, 0, 32'h0, 0, 0);
    endtask

    task automatic upd(input logic [31:0] pc, input bit mis, input bit low);
        op(0, 32'h0, 2'b00, 1'b0, "", 1, pc, mis, low);
    endtask

    task automatic idle();
        op(0, 32'h0, 2'b00, 1'b0, "", 0, 32'h0, 0, 0);
    endtask

    // Monitor: samples 2 ns after the driving negedge, well before the next posedge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (lk_valid && exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {31'b0, lk_high}, {31'b0, e});
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    localparam logic [31:0] PA = 32'h0000_1010;  // index 4
    localparam logic [31:0] PB = 32'h0000_1110;  // alias of PA (bit 8 differs)
    localparam logic [31:0] PC = 32'h0000_1014;  // index 5
    localparam logic [31:0] PD = 32'h0000_2020;  // index 8

    initial begin
        rst = 1; cfg_mode = 2'd0; cfg_thresh = 4'd3;
        lk_valid = 0; lk_pc = 0; lk_ctr = 0;
        up_valid = 0; up_pc = 0; up_mispred = 0; up_low = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R11 reset state
        #2;
        check("R11 st_misp", st_misp, 0);
        check("R11 st_low", st_low, 0);
        look(PA, 2'b00, 1'b0, "R11 table cleared");

        // R1 streak threshold
        upd(PA, 0, 1);
        upd(PA, 0, 1);
        look(PA, 2'b00, 1'b0, "R1 below threshold");
        // R8 same-cycle update and lookup: old value 2 < 3
        op(1, PA, 2'b00, 1'b0, "R8 same cycle sees old", 1, PA, 0, 1);
        look(PA, 2'b00, 1'b1, "R1 at threshold");
        // R3 aliasing and separation
        look(PB, 2'b00, 1'b1, "R3 alias shares entry");
        look(PC, 2'b00, 1'b0, "R3 neighbour separate");
        // R2 mispredict clears
        upd(PB, 1, 0);
        look(PA, 2'b00, 1'b0, "R2 cleared by mispredict");

        // R1 saturation at 15
        for (int i = 0; i < 20; i++) upd(PD, 0, 0);
        cfg_thresh = 4'd15;
        idle();
        look(PD, 2'b00, 1'b1, "R1 saturates at 15");

        // R7 change during busy cycle ignored for that lookup
        cfg_mode = 2'd1;
        look(PD, 2'b01, 1'b1, "R7 busy cycle keeps streak mode");
        idle();
        // R4 bias mode
        look(PD, 2'b01, 1'b0, "R4 ctr 01 low");
        look(PD, 2'b10, 1'b0, "R4 ctr 10 low");
        look(PD, 2'b00, 1'b1, "R4 ctr 00 high");
        look(PD, 2'b11, 1'b1, "R4 ctr 11 high");

        // R5 distance window
        cfg_mode = 2'd2;
        idle();
        look(PC, 2'b00, 1'b1, "R5 window closed");
        upd(PC, 1, 0);
        for (int i = 0; i < 4; i++) look(PC, 2'b11, 1'b0, "R5 inside window");
        look(PC, 2'b11, 1'b1, "R5 fifth lookup high");
        // R6 restart while open
        upd(PC, 1, 1);
        look(PC, 2'b11, 1'b0, "R6 first");
        look(PC, 2'b11, 1'b0, "R6 second");
        upd(PA, 1, 1);
        for (int i = 0; i < 4; i++) look(PC, 2'b11, 1'b0, "R6 restarted window");
        look(PC, 2'b11, 1'b1, "R6 window ends after restart");

        // R9/R10 statistics
        upd(PA, 0, 1);
        upd(PA, 1, 1);
        upd(PA, 1, 0);
        idle();
        #2;
        check("R9 st_misp", st_misp, e_misp);
        check("R9 st_misp_low", st_misp_low, e_misp_low);
        check("R10 st_low", st_low, e_low);
        check("R10 st_low_misp", st_low_misp, e_low_misp);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule